// File: doc/BRIEF.md
# Byte-Loaded Preset Counter

This block is a 24-bit up/down counter that a host controls over an 8-bit write/read port. The port has an active-low chip select, a command/data select and separate write and read strobes.

Data-side writes fill a 24-bit preset register one byte at a time. The byte position comes from an internal byte pointer that advances after each access. Data-side reads return the bytes of a 24-bit output latch through the same pointer.

Command-side writes carry a register selector in the top two bits. One selector value reaches a master control register, whose six action bits are one-shot commands. These commands reset the pointer, snapshot the counter, clear the counter, load the preset, clear the match flag and master-reset the block. Several bits may be set in one write. Another selector value stores six bits of input control.

The host port has no back-pressure: every strobe is accepted in the cycle it is presented, so no ready signal exists. Counting is driven by single-cycle `cnt_up` and `cnt_dn` pulses. An external `match_evt` pulse sets a sticky match flag.

Top module: `bytectr_top`

## Requirements
- R1: A write with `cs_n`=0, `cmd_sel`=0 and `wr_en`=1 stores `din` into the preset byte chosen by the pointer. Pointer 0 selects bits 7:0, pointer 1 selects bits 15:8 and pointer 2 selects bits 23:16.
- R2: Every data-side write, and every data-side read with `wr_en`=0, advances the pointer: 0 to 1, 1 to 2, and 2 back to 0. `dout` always shows the output-latch byte selected by the pointer.
- R3: A command write (`cs_n`=0, `cmd_sel`=1, `wr_en`=1) goes to the master control register when `din[7:6]`=00. It loads `din[5:0]` into `in_ctl` when `din[7:6]`=01. Selector values 10 and 11 have no effect.
- R4: Master control bit 0 returns the pointer to byte 0.
- R5: Master control bit 1 copies the counter value produced at that same edge into the output latch.
- R6: Master control bit 2 zeroes the counter, carry and borrow, and sets sign to 1.
- R7: Master control bit 3 loads the preset into the counter. Bit 4 clears the match flag, which otherwise is set by a `match_evt` pulse and holds.
- R8: When several action bits are set in one write, they take effect in this order: master reset, counter clear, preset load, latch snapshot, match clear, pointer reset.
- R9: Master control bit 5 and `rst_n`=0 both zero the counter, `in_ctl`, carry, borrow, the match flag, the latch and the pointer. Both also set the preset to all ones and set sign to 1.
- R10: Actions are one-shot: nothing acts after the cycle of the write, and no all-zero write is needed. A `cnt_up`/`cnt_dn` pulse is ignored in a cycle whose write has bit 5, 2 or 3 set.
- R11: With exactly one of `cnt_up`/`cnt_dn` high, the counter steps by one per cycle. Wrapping up from all ones sets carry and sign; wrapping down from zero sets borrow and clears sign. Both high, or both low, holds the counter.
- R12: With `cs_n`=1, writes and reads have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| cmd_sel | input | 1 | 1 = command access, 0 = data access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (data side) |
| din | input | 8 | Host write byte |
| dout | output | 8 | Output-latch byte at the pointer |
| cnt_up | input | 1 | Count-up pulse |
| cnt_dn | input | 1 | Count-down pulse |
| match_evt | input | 1 | Sets the match flag |
| count | output | 24 | Counter value |
| carry | output | 1 | Up-wrap flag |
| borrow | output | 1 | Down-wrap flag |
| sign | output | 1 | Sign flag |
| match_flag | output | 1 | Sticky match flag |
| in_ctl | output | 6 | Input control register |

## Verification
Every register result (counter, flags, `in_ctl`, preset, latch and pointer) is due one clock edge after its strobe. The bench therefore drives inputs at a falling edge and compares all outputs at the next falling edge, after exactly one rising edge. `dout` is combinational from the pointer and latch, so it is compared in that same half-cycle window. A read thus shows the byte selected before the read, and the byte after its pointer advance shows one edge later.

// File: rtl/bctr_pkg.sv
package bctr_pkg;
  localparam int ICR_W = 6;

  typedef struct packed {
    logic mrst;
    logic cmp_clr;
    logic xfer;
    logic clr;
    logic snap;
    logic ptr_rst;
  } mcr_cmd_t;

  typedef enum logic [1:0] {
    SEL_MCR  = 2'b00,
    SEL_ICR  = 2'b01,
    SEL_RSV2 = 2'b10,
    SEL_RSV3 = 2'b11
  } ctl_sel_e;
endpackage

// File: rtl/bctr_hostdec.sv
module bctr_hostdec
  import bctr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              cs_n,
  input  logic              cmd_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] din,
  output logic              data_wr,
  output logic              data_rd,
  output mcr_cmd_t          cmd,
  output logic              icr_wr,
  output logic [ICR_W-1:0]  icr_val
);
  ctl_sel_e sel;
  logic     ctl_wr;
  logic     mcr_wr;

  assign sel     = ctl_sel_e'(din[BYTE_W-1 -: 2]);
  assign ctl_wr  = !cs_n && cmd_sel && wr_en;
  assign data_wr = !cs_n && !cmd_sel && wr_en;
  assign data_rd = !cs_n && !cmd_sel && rd_en && !wr_en;
  assign mcr_wr  = ctl_wr && (sel == SEL_MCR);
  assign icr_wr  = ctl_wr && (sel == SEL_ICR);
  assign icr_val = din[ICR_W-1:0];

  always_comb begin
    cmd         = '0;
    cmd.ptr_rst = mcr_wr && din[0];
    cmd.snap    = mcr_wr && din[1];
    cmd.clr     = mcr_wr && din[2];
    cmd.xfer    = mcr_wr && din[3];
    cmd.cmp_clr = mcr_wr && din[4];
    cmd.mrst    = mcr_wr && din[5];
  end
endmodule

// File: rtl/bctr_ptr.sv
module bctr_ptr #(
  parameter int BYTES = 3,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(BYTES - 1);

  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          ptr_q <= '0;
    else if (clr)        ptr_q <= '0;
    else if (adv)        ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
  end

  assign ptr = ptr_q;

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);
  p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr_q == LAST) |=> (ptr_q == '0));
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + PW'(1)));
  p_ptr_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_q == '0));
endmodule

// File: rtl/bctr_core.sv
module bctr_core
  import bctr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 3,
  parameter int PW     = 2,
  parameter int CW     = BYTE_W * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mcr_cmd_t          cmd,
  input  logic              data_wr,
  input  logic [PW-1:0]     ptr,
  input  logic [BYTE_W-1:0] din,
  input  logic              icr_wr,
  input  logic [ICR_W-1:0]  icr_val,
  input  logic              up,
  input  logic              dn,
  input  logic              match_evt,
  output logic [CW-1:0]     cnt,
  output logic [CW-1:0]     lat,
  output logic              car,
  output logic              bor,
  output logic              sgn,
  output logic              mflag,
  output logic [ICR_W-1:0]  icr
);
  logic [CW-1:0]    cnt_q, cnt_n, pre_q, pre_n, pre_w, lat_q, lat_n;
  logic             car_q, car_n, bor_q, bor_n, sgn_q, sgn_n, mf_q, mf_n;
  logic [ICR_W-1:0] icr_q, icr_n;
  logic             hold;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign pre_w[g*BYTE_W +: BYTE_W] =
      (data_wr && ptr == PW'(g)) ? din : pre_q[g*BYTE_W +: BYTE_W];
  end

  assign hold = cmd.mrst || cmd.clr || cmd.xfer;

  always_comb begin
    cnt_n = cnt_q;
    pre_n = pre_w;
    lat_n = lat_q;
    car_n = car_q;
    bor_n = bor_q;
    sgn_n = sgn_q;
    mf_n  = mf_q || match_evt;
    icr_n = icr_wr ? icr_val : icr_q;
    if (!hold && (up ^ dn)) begin
      if (up) begin
        if (cnt_q == '1) begin
          car_n = 1'b1;
          sgn_n = 1'b1;
        end
        cnt_n = cnt_q + CW'(1);
      end else begin
        if (cnt_q == '0) begin
          bor_n = 1'b1;
          sgn_n = 1'b0;
        end
        cnt_n = cnt_q - CW'(1);
      end
    end
    if (cmd.mrst) begin
      cnt_n = '0;
      pre_n = '1;
      lat_n = '0;
      car_n = 1'b0;
      bor_n = 1'b0;
      sgn_n = 1'b1;
      mf_n  = 1'b0;
      icr_n = '0;
    end
    if (cmd.clr) begin
      cnt_n = '0;
      car_n = 1'b0;
      bor_n = 1'b0;
      sgn_n = 1'b1;
    end
    if (cmd.xfer)    cnt_n = pre_n;
    if (cmd.snap)    lat_n = cnt_n;
    if (cmd.cmp_clr) mf_n  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '1;
      lat_q <= '0;
      car_q <= 1'b0;
      bor_q <= 1'b0;
      sgn_q <= 1'b1;
      mf_q  <= 1'b0;
      icr_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      pre_q <= pre_n;
      lat_q <= lat_n;
      car_q <= car_n;
      bor_q <= bor_n;
      sgn_q <= sgn_n;
      mf_q  <= mf_n;
      icr_q <= icr_n;
    end
  end

  assign cnt   = cnt_q;
  assign lat   = lat_q;
  assign car   = car_q;
  assign bor   = bor_q;
  assign sgn   = sgn_q;
  assign mflag = mf_q;
  assign icr   = icr_q;

  p_mreset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.mrst && !cmd.xfer) |=> (cnt_q == '0 && pre_q == '1 && sgn_q && !mf_q));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.clr && !cmd.xfer) |=> (cnt_q == '0 && !car_q && !bor_q && sgn_q));
  p_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.xfer && !cmd.mrst) |=> (cnt_q == $past(pre_q)));
  p_clear_then_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.clr && cmd.xfer && cmd.snap && !cmd.mrst) |=> (lat_q == cnt_q));
  p_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn && !hold && cnt_q == '1) |=> (car_q && cnt_q == '0));
  p_borrow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dn && !up && !hold && cnt_q == '0) |=> (bor_q && !sgn_q && cnt_q == '1));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !(up ^ dn)) |=> $stable(cnt_q));
  p_match_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.cmp_clr |=> !mf_q);
endmodule

// File: rtl/bytectr_top.sv
module bytectr_top
  import bctr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     cmd_sel,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [BYTE_W-1:0]        din,
  output logic [BYTE_W-1:0]        dout,
  input  logic                     cnt_up,
  input  logic                     cnt_dn,
  input  logic                     match_evt,
  output logic [BYTE_W*BYTES-1:0]  count,
  output logic                     carry,
  output logic                     borrow,
  output logic                     sign,
  output logic                     match_flag,
  output logic [ICR_W-1:0]         in_ctl
);
  localparam int CW = BYTE_W * BYTES;
  localparam int PW = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic             data_wr, data_rd, icr_wr;
  mcr_cmd_t         cmd;
  logic [ICR_W-1:0] icr_val;
  logic [PW-1:0]    ptr;
  logic [CW-1:0]    lat;

  bctr_hostdec #(.BYTE_W(BYTE_W)) u_dec (
    .cs_n(cs_n), .cmd_sel(cmd_sel), .wr_en(wr_en), .rd_en(rd_en), .din(din),
    .data_wr(data_wr), .data_rd(data_rd), .cmd(cmd),
    .icr_wr(icr_wr), .icr_val(icr_val)
  );

  bctr_ptr #(.BYTES(BYTES), .PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .adv(data_wr || data_rd),
    .clr(cmd.ptr_rst || cmd.mrst),
    .ptr(ptr)
  );

  bctr_core #(.BYTE_W(BYTE_W), .BYTES(BYTES), .PW(PW), .CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .data_wr(data_wr), .ptr(ptr),
    .din(din), .icr_wr(icr_wr), .icr_val(icr_val),
    .up(cnt_up), .dn(cnt_dn), .match_evt(match_evt),
    .cnt(count), .lat(lat), .car(carry), .bor(borrow), .sgn(sign),
    .mflag(match_flag), .icr(in_ctl)
  );

  always_comb begin
    dout = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (ptr == PW'(i)) dout = lat[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: tb/sim_bytectr_top.sv
`timescale 1ns/1ps
module sim_bytectr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, cmd_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  din = '0;
  logic        cnt_up = 1'b0, cnt_dn = 1'b0, match_evt = 1'b0;
  logic [7:0]  dout;
  logic [23:0] count;
  logic        carry, borrow, sign, match_flag;
  logic [5:0]  in_ctl;

  int n_cmp = 0;
  int n_bad = 0;

  logic [23:0] m_cnt, m_pre, m_lat;
  logic        m_car, m_bor, m_sgn, m_mf;
  logic [5:0]  m_icr;
  int          m_ptr;

  always #2.5 clk = ~clk;

  bytectr_top u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_sel(cmd_sel), .wr_en(wr_en),
    .rd_en(rd_en), .din(din), .dout(dout), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .match_evt(match_evt), .count(count), .carry(carry), .borrow(borrow),
    .sign(sign), .match_flag(match_flag), .in_ctl(in_ctl)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic mdl_reset();
    m_cnt = '0; m_pre = '1; m_lat = '0; m_car = 1'b0; m_bor = 1'b0;
    m_sgn = 1'b1; m_mf = 1'b0; m_icr = '0; m_ptr = 0;
  endtask

  // next-state of the model from the current inputs, per R1..R12
  task automatic mdl_step();
    logic dwr, drd, mw, iw, hold;
    dwr  = !cs_n && !cmd_sel && wr_en;
    drd  = !cs_n && !cmd_sel && rd_en && !wr_en;
    mw   = !cs_n && cmd_sel && wr_en && din[7:6] == 2'b00;
    iw   = !cs_n && cmd_sel && wr_en && din[7:6] == 2'b01;
    hold = mw && (din[5] || din[2] || din[3]);
    if (match_evt) m_mf = 1'b1;
    if (iw) m_icr = din[5:0];
    if (dwr) m_pre[m_ptr*8 +: 8] = din;
    if (!hold && (cnt_up != cnt_dn)) begin
      if (cnt_up) begin
        if (m_cnt == 24'hFFFFFF) begin m_car = 1'b1; m_sgn = 1'b1; end
        m_cnt = m_cnt + 24'd1;
      end else begin
        if (m_cnt == 24'd0) begin m_bor = 1'b1; m_sgn = 1'b0; end
        m_cnt = m_cnt - 24'd1;
      end
    end
    if (mw && din[5]) begin
      m_cnt = '0; m_pre = '1; m_lat = '0; m_car = 1'b0; m_bor = 1'b0;
      m_sgn = 1'b1; m_mf = 1'b0; m_icr = '0;
    end
    if (mw && din[2]) begin m_cnt = '0; m_car = 1'b0; m_bor = 1'b0; m_sgn = 1'b1; end
    if (mw && din[3]) m_cnt = m_pre;
    if (mw && din[1]) m_lat = m_cnt;
    if (mw && din[4]) m_mf = 1'b0;
    if (mw && (din[0] || din[5])) m_ptr = 0;
    else if (dwr || drd) m_ptr = (m_ptr + 1) % 3;
  endtask

  task automatic check_all(input string tag);
    chk(tag, "count", 32'(count), 32'(m_cnt));
    chk(tag, "carry", 32'(carry), 32'(m_car));
    chk(tag, "borrow", 32'(borrow), 32'(m_bor));
    chk(tag, "sign", 32'(sign), 32'(m_sgn));
    chk(tag, "match_flag", 32'(match_flag), 32'(m_mf));
    chk(tag, "in_ctl", 32'(in_ctl), 32'(m_icr));
    chk(tag, "dout", 32'(dout), 32'(m_lat[m_ptr*8 +: 8]));
  endtask

  task automatic idle();
    cs_n = 1'b1; cmd_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; din = '0;
    cnt_up = 1'b0; cnt_dn = 1'b0; match_evt = 1'b0;
  endtask

  task automatic step(input string tag);
    #1 chk(tag, "dout_pre", 32'(dout), 32'(m_lat[m_ptr*8 +: 8]));
    @(posedge clk);
    mdl_step();
    @(negedge clk);
    check_all(tag);
    idle();
  endtask

  task automatic dwrite(input logic [7:0] d, input string tag);
    cs_n = 1'b0; cmd_sel = 1'b0; wr_en = 1'b1; din = d; step(tag);
  endtask
  task automatic dread(input string tag);
    cs_n = 1'b0; cmd_sel = 1'b0; rd_en = 1'b1; step(tag);
  endtask
  task automatic cwrite(input logic [7:0] d, input string tag);
    cs_n = 1'b0; cmd_sel = 1'b1; wr_en = 1'b1; din = d; step(tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C7A));
    idle();
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R9_reset");
    // R1 byte lanes then R7 preset load
    dwrite(8'h11, "R1"); dwrite(8'h22, "R1"); dwrite(8'h33, "R1");
    cwrite(8'h08, "R7_load");
    // R5 snapshot, R2 reads with wrap
    cwrite(8'h02, "R5_snap");
    repeat (4) dread("R2_read");
    // R12 deselected accesses ignored
    cs_n = 1'b1; cmd_sel = 1'b1; wr_en = 1'b1; din = 8'h24; step("R12_cmd");
    cs_n = 1'b1; cmd_sel = 1'b0; wr_en = 1'b1; din = 8'hAA; step("R12_data");
    cs_n = 1'b1; rd_en = 1'b1; step("R12_read");
    cwrite(8'h08, "R12_load");
    // R3 register select
    cwrite(8'h6A, "R3_icr");
    cwrite(8'hBF, "R3_rsv");
    cwrite(8'hC4, "R3_rsv");
    // R9 master reset then preset load of all ones, R11 carry
    cwrite(8'h20, "R9_mreset");
    cwrite(8'h08, "R9_preset");
    cnt_up = 1'b1; step("R11_carry");
    cnt_up = 1'b1; step("R11_up");
    cnt_up = 1'b1; cnt_dn = 1'b1; step("R11_both");
    // R6 clear then R11 borrow
    cwrite(8'h04, "R6_clear");
    cnt_dn = 1'b1; step("R11_borrow");
    // R10 count ignored during a clear
    cnt_up = 1'b1; cs_n = 1'b0; cmd_sel = 1'b1; wr_en = 1'b1; din = 8'h04; step("R10_hold");
    // R8 combined: clear + load + snapshot
    dwrite(8'h5A, "R1"); dwrite(8'hC3, "R1");
    cwrite(8'h0E, "R8_combo");
    dread("R8_read");
    // R7 match flag, R4 pointer reset
    match_evt = 1'b1; step("R7_match");
    step("R10_idle");
    cwrite(8'h11, "R7_R4");
    match_evt = 1'b1; cs_n = 1'b0; cmd_sel = 1'b1; wr_en = 1'b1; din = 8'h10; step("R8_mclr");
    cwrite(8'h2A, "R8_mrst_combo");
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      cnt_up    = ($urandom_range(0, 2) == 0);
      cnt_dn    = ($urandom_range(0, 3) == 0);
      match_evt = ($urandom_range(0, 15) == 0);
      case (op)
        0, 1: begin cs_n = 1'b0; wr_en = 1'b1; din = 8'($urandom); step("R1_rand"); end
        2, 3: begin cs_n = 1'b0; rd_en = 1'b1; wr_en = ($urandom_range(0, 7) == 0); step("R2_rand"); end
        4: begin cs_n = 1'b0; cmd_sel = 1'b1; wr_en = 1'b1;
                 din = {2'b00, ($urandom_range(0, 7) == 0), 5'($urandom)}; step("R8_rand"); end
        5: begin cs_n = 1'b0; cmd_sel = 1'b1; wr_en = 1'b1; din = 8'($urandom);
                 if (din[7:6] == 2'b00) din[5] = 1'b0; step("R3_rand"); end
        6: begin cs_n = 1'b1; cmd_sel = 1'($urandom); wr_en = 1'b1; rd_en = 1'($urandom);
                 din = 8'($urandom); step("R12_rand"); end
        default: step("R11_rand");
      endcase
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule